// File: doc/BRIEF.md
# Two-Bank SDRAM Write Command Sequencer

This block converts host write requests into the command stream of a two-bank SDRAM. A request names a bank, a row, a start column, a burst of `BL` data words and a flag asking for the bank to be closed automatically after the burst. The sequencer holds one request at a time. It decides whether the target bank needs a precharge, an activate, or only the write. It then issues ACT, WRITE, PRE or NOP on a registered command bus, and puts the burst on DQ.

Each bank has its own small set of down-counters. They enforce four delays: activate-to-write, last-data-to-precharge, the internal precharge that follows an auto-precharge write, and precharge-to-activate. Because the counters are per bank, a request for one bank can activate its row while the other bank's burst is still on DQ. Back-to-back writes to alternate banks can therefore keep the data bus busy without a gap.

Top module: `sdw_write_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, the command bus carries NOP (code 3'b111), `req_ready` is high and `sd_dq_oe` is low.
- R2: A WRITE to a bank is issued no earlier than `TRCD` cycles after that bank's ACT. When nothing else holds it back, it is issued exactly `TRCD` cycles after the ACT.
- R3: An ACT carries the request row on `sd_addr[10:0]` and the request bank on `sd_ba`.
- R4: A WRITE carries the start column on `sd_addr[7:0]` and zero on `sd_addr[9:8]`. `sd_addr[10]` equals the request's auto-precharge flag.
- R5: Burst word k (bits `[k*DW +: DW]` of `req_data`) is on `sd_dq` in the k-th cycle counted from the WRITE cycle as cycle 0. `sd_dq_oe` is high for exactly those `BL` cycles.
- R6: A request to a bank that is already open on the same row produces a WRITE alone, with no ACT and no PRE.
- R7: A request to an open bank on a different row first issues a PRE (`sd_addr[10]` low), exactly `BL-1+TRDL` cycles after the previous WRITE to that bank when the request is already waiting.
- R8: The ACT that follows an explicit PRE to a bank comes exactly `TRP` cycles after that PRE.
- R9: After a WRITE with auto-precharge, no PRE is issued to that bank. The next ACT to it comes no earlier than `BL-1+TWR+TRP` cycles after the WRITE, and exactly then if a request for it is waiting.
- R10: Writes to alternate banks run gaplessly. The second bank's ACT may fall inside the first bank's burst, and its WRITE follows the first WRITE by exactly `BL` cycles.
- R11: `req_ready` drops in the cycle after a request is accepted and stays low until that request's WRITE has been issued.
- R12: Commands are encoded on `sd_cmd` = {RAS#, CAS#, WE#` } as ACT 3'b011, WRITE 3'b100, PRE 3'b010 and NOP 3'b111. No other code ever appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Sequencer can take a request |
| req_bank | input | 1 | Target bank |
| req_row | input | 11 | Target row |
| req_col | input | 8 | Burst start column |
| req_ap | input | 1 | Close the bank automatically after the burst |
| req_data | input | BL*DW | Burst words, word 0 in the low bits |
| sd_cmd | output | 3 | {RAS#, CAS#, WE#} command code |
| sd_addr | output | 11 | Multiplexed row/column address |
| sd_ba | output | 1 | Bank select |
| sd_dq | output | DW | Write data |
| sd_dq_oe | output | 1 | Data output enable |

## Verification
The bench sends each request as soon as `req_ready` rises, so every delay is hit on its exact cycle. A design that is one cycle early or late in its counter reload will miss the expected PRE, ACT or WRITE cycle.

A row miss issued directly behind a write tests the write-recovery gap. An auto-precharge write followed by a request to the same bank tests two faults: a design that emits a real PRE, and one that reopens the bank before the internal precharge and row precharge have both elapsed.

Two alternating-bank pairs test interleaving. One pair hits rows that are already open. The other pair finds both banks closed, so the second ACT must overlap the first burst. A design that waits for DQ to drain before activating, or that lets one bank's timers block the other, leaves a gap in the data.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

    localparam int ROW_W = 11;
    localparam int COL_W = 8;
    localparam int NBANK = 2;

    // {ras_n, cas_n, we_n}
    typedef enum logic [2:0] {
        CMD_ACT = 3'b011,
        CMD_WR  = 3'b100,
        CMD_PRE = 3'b010,
        CMD_NOP = 3'b111
    } sd_cmd_t;

    typedef struct packed {
        logic             bank;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic             ap;
    } wr_req_t;

    // Address bus contents for a given command.
    function automatic logic [ROW_W-1:0] cmd_addr(sd_cmd_t c, wr_req_t r);
        logic [ROW_W-1:0] a;
        a = '0;
        case (c)
            CMD_ACT: a = r.row;
            CMD_WR:  a = {r.ap, {(ROW_W-COL_W-1){1'b0}}, r.col};
            default: a = '0;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/sdw_bank_timer.sv
module sdw_bank_timer
    import sdw_pkg::*;
#(
    parameter int BL   = 4,
    parameter int TRCD = 2,
    parameter int TRDL = 2,
    parameter int TWR  = 2,
    parameter int TRP  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             do_act,
    input  logic             do_wr,
    input  logic             do_pre,
    input  logic             wr_ap,
    input  logic [ROW_W-1:0] act_row,
    output logic             is_open,
    output logic [ROW_W-1:0] open_row,
    output logic             can_act,
    output logic             can_wr,
    output logic             can_pre
);
    localparam int CW = $clog2(BL + TRCD + TRDL + TWR + TRP + 2);
    // Commands leave through a register: load N-1 so the decision lands N cycles later.
    localparam logic [CW-1:0] RCD_LD = CW'(TRCD - 1);
    localparam logic [CW-1:0] REC_LD = CW'(BL - 1 + TRDL - 1);
    localparam logic [CW-1:0] AP_LD  = CW'(BL - 1 + TWR + TRP - 1);
    localparam logic [CW-1:0] RP_LD  = CW'(TRP - 1);

    logic [CW-1:0] rcd_q, rec_q, rp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rcd_q    <= '0;
            rec_q    <= '0;
            rp_q     <= '0;
            is_open  <= 1'b0;
            open_row <= '0;
        end else begin
            if (do_act)           rcd_q <= RCD_LD;
            else if (rcd_q != 0)  rcd_q <= rcd_q - 1'b1;

            if (do_wr)            rec_q <= REC_LD;
            else if (rec_q != 0)  rec_q <= rec_q - 1'b1;

            if (do_pre)                rp_q <= RP_LD;
            else if (do_wr && wr_ap)   rp_q <= AP_LD;
            else if (rp_q != 0)        rp_q <= rp_q - 1'b1;

            if (do_act) begin
                is_open  <= 1'b1;
                open_row <= act_row;
            end else if (do_pre || (do_wr && wr_ap)) begin
                is_open  <= 1'b0;
            end
        end
    end

    assign can_act = !is_open && (rp_q == 0);
    assign can_wr  = is_open && (rcd_q == 0);
    assign can_pre = is_open && (rec_q == 0);

endmodule

// File: rtl/sdw_burst.sv
module sdw_burst #(
    parameter int BL = 4,
    parameter int DW = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [BL*DW-1:0] words,
    output logic [DW-1:0]  dq,
    output logic           dq_oe,
    output logic           free
);
    localparam int LW = $clog2(BL) + 1;

    logic [BL*DW-1:0] shreg;
    logic [LW-1:0]    left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg  <= '0;
            left_q <= '0;
            dq     <= '0;
            dq_oe  <= 1'b0;
        end else if (load) begin
            dq     <= words[DW-1:0];
            shreg  <= words >> DW;
            left_q <= LW'(BL - 1);
            dq_oe  <= 1'b1;
        end else if (left_q != 0) begin
            dq     <= shreg[DW-1:0];
            shreg  <= shreg >> DW;
            left_q <= left_q - 1'b1;
            dq_oe  <= 1'b1;
        end else begin
            dq     <= '0;
            dq_oe  <= 1'b0;
        end
    end

    // The bus cycle now showing is the last word (or none): a WRITE decided now follows seamlessly.
    assign free = (left_q == 0);

endmodule

// File: rtl/sdw_write_seq.sv
module sdw_write_seq
    import sdw_pkg::*;
#(
    parameter int DW   = 16,
    parameter int BL   = 4,
    parameter int TRCD = 2,
    parameter int TRDL = 2,
    parameter int TWR  = 2,
    parameter int TRP  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_bank,
    input  logic [10:0]      req_row,
    input  logic [7:0]       req_col,
    input  logic             req_ap,
    input  logic [BL*DW-1:0] req_data,
    output logic [2:0]       sd_cmd,
    output logic [10:0]      sd_addr,
    output logic             sd_ba,
    output logic [DW-1:0]    sd_dq,
    output logic             sd_dq_oe
);
    logic             p_valid;
    wr_req_t          p_q;
    logic [BL*DW-1:0] p_data;

    logic             b_open   [NBANK];
    logic [ROW_W-1:0] b_row    [NBANK];
    logic             b_can_act[NBANK];
    logic             b_can_wr [NBANK];
    logic             b_can_pre[NBANK];

    sd_cmd_t next_cmd;
    logic    dq_free;
    sd_cmd_t cmd_q;

    assign req_ready = !p_valid;

    // Next step for the held request, taken only when its bank allows it.
    always_comb begin
        next_cmd = CMD_NOP;
        if (p_valid) begin
            if (b_open[p_q.bank]) begin
                if (b_row[p_q.bank] == p_q.row) begin
                    if (b_can_wr[p_q.bank] && dq_free) next_cmd = CMD_WR;
                end else if (b_can_pre[p_q.bank]) begin
                    next_cmd = CMD_PRE;
                end
            end else if (b_can_act[p_q.bank]) begin
                next_cmd = CMD_ACT;
            end
        end
    end

    for (genvar i = 0; i < NBANK; i++) begin : g_bank
        sdw_bank_timer #(
            .BL(BL), .TRCD(TRCD), .TRDL(TRDL), .TWR(TWR), .TRP(TRP)
        ) u_tmr (
            .clk     (clk),
            .rst     (rst),
            .do_act  (next_cmd == CMD_ACT && p_q.bank == 1'(i)),
            .do_wr   (next_cmd == CMD_WR  && p_q.bank == 1'(i)),
            .do_pre  (next_cmd == CMD_PRE && p_q.bank == 1'(i)),
            .wr_ap   (p_q.ap),
            .act_row (p_q.row),
            .is_open (b_open[i]),
            .open_row(b_row[i]),
            .can_act (b_can_act[i]),
            .can_wr  (b_can_wr[i]),
            .can_pre (b_can_pre[i])
        );
    end

    sdw_burst #(.BL(BL), .DW(DW)) u_burst (
        .clk  (clk),
        .rst  (rst),
        .load (next_cmd == CMD_WR),
        .words(p_data),
        .dq   (sd_dq),
        .dq_oe(sd_dq_oe),
        .free (dq_free)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            p_valid <= 1'b0;
            p_q     <= '0;
            p_data  <= '0;
            cmd_q   <= CMD_NOP;
            sd_addr <= '0;
            sd_ba   <= 1'b0;
        end else begin
            if (req_valid && req_ready) begin
                p_valid  <= 1'b1;
                p_q.bank <= req_bank;
                p_q.row  <= req_row;
                p_q.col  <= req_col;
                p_q.ap   <= req_ap;
                p_data   <= req_data;
            end else if (next_cmd == CMD_WR) begin
                p_valid <= 1'b0;
            end
            cmd_q   <= next_cmd;
            sd_addr <= cmd_addr(next_cmd, p_q);
            sd_ba   <= (next_cmd == CMD_NOP) ? 1'b0 : p_q.bank;
        end
    end

    assign sd_cmd = cmd_q;

endmodule

// File: rtl/sdw_write_seq_chk.sv
module sdw_write_seq_chk
    import sdw_pkg::*;
#(
    parameter int BL   = 4,
    parameter int TRCD = 2,
    parameter int TRDL = 2,
    parameter int TWR  = 2,
    parameter int TRP  = 3
) (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_ready,
    input logic [2:0] sd_cmd,
    input logic       sd_ba,
    input logic [10:0] sd_addr,
    input logic       sd_dq_oe
);
    logic [7:0] since_act[NBANK];
    logic [7:0] since_wr [NBANK];
    logic [7:0] since_ap [NBANK];
    logic [7:0] since_pre[NBANK];
    logic [7:0] brem;

    function automatic logic [7:0] bump(logic [7:0] v);
        return (v == 8'hFF) ? v : v + 8'd1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < NBANK; b++) begin
                since_act[b] <= 8'hFF;
                since_wr[b]  <= 8'hFF;
                since_ap[b]  <= 8'hFF;
                since_pre[b] <= 8'hFF;
            end
            brem <= '0;
        end else begin
            for (int b = 0; b < NBANK; b++) begin
                logic hit;
                hit = (sd_ba == 1'(b));
                since_act[b] <= (hit && sd_cmd == CMD_ACT) ? 8'd1 : bump(since_act[b]);
                since_pre[b] <= (hit && sd_cmd == CMD_PRE) ? 8'd1 : bump(since_pre[b]);
                since_wr[b]  <= (hit && sd_cmd == CMD_WR)  ? 8'd1 : bump(since_wr[b]);
                since_ap[b]  <= (hit && sd_cmd == CMD_WR && sd_addr[10]) ? 8'd1 : bump(since_ap[b]);
            end
            if (sd_cmd == CMD_WR) brem <= 8'(BL - 1);
            else if (brem != 0)   brem <= brem - 8'd1;
        end
    end

    // R1
    reset_nop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (sd_cmd == CMD_NOP && !sd_dq_oe));

    // R2
    act_to_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (sd_cmd == CMD_WR) |-> (32'(since_act[sd_ba]) >= TRCD));

    // R5
    burst_oe_chk: assert property (@(posedge clk) disable iff (rst)
        sd_dq_oe == (sd_cmd == CMD_WR || brem != 0));

    // R7
    wr_to_pre_chk: assert property (@(posedge clk) disable iff (rst)
        (sd_cmd == CMD_PRE) |-> (32'(since_wr[sd_ba]) >= BL - 1 + TRDL));

    // R8
    pre_to_act_chk: assert property (@(posedge clk) disable iff (rst)
        (sd_cmd == CMD_ACT) |-> (32'(since_pre[sd_ba]) >= TRP));

    // R9
    ap_to_act_chk: assert property (@(posedge clk) disable iff (rst)
        (sd_cmd == CMD_ACT) |-> (32'(since_ap[sd_ba]) >= BL - 1 + TWR + TRP));

    // R11
    hold_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R12
    legal_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        sd_cmd inside {CMD_ACT, CMD_WR, CMD_PRE, CMD_NOP});

endmodule

bind sdw_write_seq sdw_write_seq_chk #(
    .BL(BL), .TRCD(TRCD), .TRDL(TRDL), .TWR(TWR), .TRP(TRP)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .sd_cmd   (sd_cmd),
    .sd_ba    (sd_ba),
    .sd_addr  (sd_addr),
    .sd_dq_oe (sd_dq_oe)
);

// File: tb/sdw_write_seq_test.sv
module sdw_write_seq_test;
    localparam int DW = 16, BL = 4, TRCD = 2, TRDL = 2, TWR = 2, TRP = 3;
    localparam logic [2:0] C_ACT = 3'b011, C_WR = 3'b100, C_PRE = 3'b010, C_NOP = 3'b111;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0, req_bank = 1'b0, req_ap = 1'b0;
    logic [10:0] req_row = '0;
    logic [7:0]  req_col = '0;
    logic [BL*DW-1:0] req_data = '0;
    logic req_ready, sd_ba, sd_dq_oe;
    logic [2:0] sd_cmd;
    logic [10:0] sd_addr;
    logic [DW-1:0] sd_dq;

    always #5 clk = ~clk;

    sdw_write_seq #(.DW(DW), .BL(BL), .TRCD(TRCD), .TRDL(TRDL), .TWR(TWR), .TRP(TRP)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_ap(req_ap),
        .req_data(req_data), .sd_cmd(sd_cmd), .sd_addr(sd_addr), .sd_ba(sd_ba),
        .sd_dq(sd_dq), .sd_dq_oe(sd_dq_oe));

    int nchk = 0, nfail = 0, cyc = 0, ncmd = 0;
    bit done = 0;
    int          l_cyc [256];
    logic [2:0]  l_cmd [256];
    logic [10:0] l_addr[256];
    logic        l_ba  [256];
    logic [DW-1:0] dq_log[4096];
    logic          oe_log[4096];

    always @(negedge clk) begin
        cyc++;
        if (cyc < 4096) begin
            dq_log[cyc] = sd_dq;
            oe_log[cyc] = sd_dq_oe;
        end
        if (!rst && sd_cmd != C_NOP && ncmd < 256) begin
            l_cyc[ncmd] = cyc; l_cmd[ncmd] = sd_cmd;
            l_addr[ncmd] = sd_addr; l_ba[ncmd] = sd_ba;
            ncmd++;
        end
    end

    task automatic chk(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int find(int from, logic [2:0] c, logic b);
        for (int i = from; i < ncmd; i++)
            if (l_cmd[i] == c && l_ba[i] == b) return i;
        return -1;
    endfunction

    function automatic int cy(int idx);
        return (idx < 0) ? -1000 : l_cyc[idx];
    endfunction

    task automatic send(logic b, logic [10:0] row, logic [7:0] col, logic ap, logic [15:0] base);
        logic seen;
        req_valid = 1'b1; req_bank = b; req_row = row; req_col = col; req_ap = ap;
        for (int k = 0; k < BL; k++) req_data[k*DW +: DW] = base + 16'(k);
        forever begin
            seen = req_ready;
            @(negedge clk);
            if (seen) break;
        end
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        while (quiet < 12) begin
            @(negedge clk);
            if (req_ready && !sd_dq_oe && sd_cmd == C_NOP) quiet++;
            else quiet = 0;
        end
    endtask

    task automatic burst_ok(string req, int wc, logic [15:0] base);
        for (int k = 0; k < BL; k++) begin
            chk(req, int'(dq_log[wc+k]), int'(base + 16'(k)));
            chk(req, int'(oe_log[wc+k]), 1);
        end
    endtask

    task automatic t_reset();
        chk("R1 cmd", int'(sd_cmd), int'(C_NOP));
        chk("R1 ready", int'(req_ready), 1);
        chk("R1 oe", int'(sd_dq_oe), 0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R1 cmd after release", int'(sd_cmd), int'(C_NOP));
        chk("R1 ready after release", int'(req_ready), 1);
    endtask

    task automatic t_first_write();
        int s = ncmd, a, w;
        send(1'b0, 11'd5, 8'h12, 1'b0, 16'hA000);
        chk("R11 ready low while held", int'(req_ready), 0);
        wait_idle();
        a = find(s, C_ACT, 1'b0); w = find(s, C_WR, 1'b0);
        chk("R12 ACT code seen", int'(a >= 0), 1);
        chk("R12 WRITE code seen", int'(w >= 0), 1);
        chk("R3 act row", int'(l_addr[a]), 5);
        chk("R3 act bank", int'(l_ba[a]), 0);
        chk("R2 act to write", cy(w) - cy(a), TRCD);
        chk("R4 col", int'(l_addr[w][7:0]), 8'h12);
        chk("R4 high bits", int'(l_addr[w][10:8]), 0);
        burst_ok("R5 data", cy(w), 16'hA000);
        chk("R5 oe before", int'(oe_log[cy(w)-1]), 0);
        chk("R5 oe after", int'(oe_log[cy(w)+BL]), 0);
    endtask

    task automatic t_row_hit();
        int s = ncmd, w;
        send(1'b0, 11'd5, 8'h20, 1'b0, 16'hB000);
        wait_idle();
        w = find(s, C_WR, 1'b0);
        chk("R6 no ACT", find(s, C_ACT, 1'b0), -1);
        chk("R6 no PRE", find(s, C_PRE, 1'b0), -1);
        chk("R4 col row hit", int'(l_addr[w][7:0]), 8'h20);
        burst_ok("R6 data", cy(w), 16'hB000);
    endtask

    task automatic t_row_miss();
        int s = ncmd, w1, p, a, w2;
        send(1'b0, 11'd5, 8'h30, 1'b0, 16'hC000);
        send(1'b0, 11'd9, 8'h40, 1'b0, 16'hC100);
        wait_idle();
        w1 = find(s, C_WR, 1'b0); p = find(s, C_PRE, 1'b0);
        a = find(s, C_ACT, 1'b0); w2 = find(w1 + 1, C_WR, 1'b0);
        chk("R7 write to pre", cy(p) - cy(w1), BL - 1 + TRDL);
        chk("R7 pre a10 low", int'(l_addr[p][10]), 0);
        chk("R8 pre to act", cy(a) - cy(p), TRP);
        chk("R3 new row", int'(l_addr[a]), 9);
        chk("R2 act to write miss", cy(w2) - cy(a), TRCD);
        burst_ok("R5 data after miss", cy(w2), 16'hC100);
    endtask

    task automatic t_auto_pre();
        int s = ncmd, w1, a2, w2;
        send(1'b1, 11'd3, 8'h50, 1'b1, 16'hD000);
        send(1'b1, 11'd3, 8'h60, 1'b0, 16'hD100);
        wait_idle();
        w1 = find(s, C_WR, 1'b1); a2 = find(w1 + 1, C_ACT, 1'b1);
        w2 = find(w1 + 1, C_WR, 1'b1);
        chk("R4 a10 high", int'(l_addr[w1][10]), 1);
        chk("R9 no explicit PRE", find(s, C_PRE, 1'b1), -1);
        chk("R9 ap write to act", cy(a2) - cy(w1), BL - 1 + TWR + TRP);
        chk("R2 write after reopen", cy(w2) - cy(a2), TRCD);
        burst_ok("R5 data after reopen", cy(w2), 16'hD100);
    endtask

    task automatic t_interleave_hits();
        int s = ncmd, wa, wb;
        send(1'b0, 11'd9, 8'h70, 1'b1, 16'hE000);
        send(1'b1, 11'd3, 8'h74, 1'b1, 16'hE100);
        wait_idle();
        wa = find(s, C_WR, 1'b0); wb = find(s, C_WR, 1'b1);
        chk("R10 gapless hits", cy(wb) - cy(wa), BL);
        burst_ok("R10 first burst", cy(wa), 16'hE000);
        burst_ok("R10 second burst", cy(wb), 16'hE100);
    endtask

    task automatic t_interleave_closed();
        int s = ncmd, aa, wa, ab, wb;
        send(1'b0, 11'd4, 8'h08, 1'b1, 16'hF000);
        send(1'b1, 11'd6, 8'h0C, 1'b1, 16'hF100);
        wait_idle();
        aa = find(s, C_ACT, 1'b0); wa = find(s, C_WR, 1'b0);
        ab = find(s, C_ACT, 1'b1); wb = find(s, C_WR, 1'b1);
        chk("R2 bank0 act to write", cy(wa) - cy(aa), TRCD);
        chk("R10 act inside burst", int'(cy(ab) > cy(wa) && cy(ab) < cy(wa) + BL), 1);
        chk("R10 gapless closed", cy(wb) - cy(wa), BL);
        chk("R3 bank1 row", int'(l_addr[ab]), 6);
        burst_ok("R10 closed data a", cy(wa), 16'hF000);
        burst_ok("R10 closed data b", cy(wb), 16'hF100);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_first_write();
        t_row_hit();
        t_row_miss();
        t_auto_pre();
        t_interleave_hits();
        t_interleave_closed();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

endmodule